// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This block is the integer multiply and divide unit of a classic RISC pipeline. It owns two architectural result registers, HI and LO, which together form one 64-bit value (HI upper, LO lower). A start strobe with an operation code and two 32-bit operands launches one operation. A product can overwrite the pair, or be added to or subtracted from the pair, which acts as the accumulator. A wide multiply takes the whole 64-bit pair as one operand. A signed divide leaves the remainder in HI and the quotient in LO.

The pipeline reads HI and LO straight from the output ports. It can also load either register through its own write port, but only while the unit is idle. `busy` shows that an operation is in flight. `done` pulses for one cycle in the cycle where the new HI and LO are first visible.

Top module: `hilo_mac_unit`

## Requirements
- R1: After reset, HI, LO, `busy` and `done` are all zero.
- R2: Op code 0 is a signed multiply. Both operands are sign-extended to 64 bits and the product is written to HI:LO.
- R3: Op code 1 is an unsigned multiply. Both operands are zero-extended and the 64-bit product is written to HI:LO.
- R4: Op codes 2 (signed) and 3 (unsigned) are multiply-add. The 64-bit product is added to HI:LO and the sum, modulo 2^64, is written back.
- R5: Op codes 4 (signed) and 5 (unsigned) are multiply-subtract. The product is subtracted from HI:LO, modulo 2^64.
- R6: Op code 6 is a wide multiply. HI:LO is treated as a 64-bit operand and multiplied by the sign-extended operand A. The low 64 bits of the result are written to HI:LO. The HI:LO value used is the one held in the start cycle, before any direct write made in that same cycle.
- R7: An accepted multiply-class operation (codes 0 to 6) holds `busy` high for exactly one cycle. In the next cycle `done` is high for one cycle, `busy` is low and the new HI and LO are visible.
- R8: Op code 7 is a signed divide A/B. The quotient rounds toward zero and goes to LO. The remainder takes the sign of A and goes to HI. The case -2^31 / -1 gives quotient 0x80000000 and remainder 0.
- R9: An accepted divide holds `busy` high for 33 cycles. It then raises `done` for one cycle with the results visible.
- R10: A divide by zero keeps the R9 timing but leaves HI and LO unchanged.
- R11: While `busy` is low, `hi_wr_en` and `lo_wr_en` load HI and LO on the next edge. When a multiply-add or multiply-subtract starts in the same cycle as a write, it accumulates onto the written value.
- R12: Direct writes made while `busy` is high have no effect.
- R13: A start while `busy` is high is ignored. A start with op code 8 to 15 is ignored: `busy` stays low and HI and LO keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch an operation this cycle |
| op | input | 4 | Operation code (see R2 to R13) |
| opnd_a | input | 32 | First operand / dividend |
| opnd_b | input | 32 | Second operand / divisor |
| hi_wr_en | input | 1 | Direct load of HI |
| hi_wr_data | input | 32 | Value for HI |
| lo_wr_en | input | 1 | Direct load of LO |
| lo_wr_data | input | 32 | Value for LO |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| hi_q | output | 32 | HI register |
| lo_q | output | 32 | LO register |

## Verification
A wrong product or a stale accumulator operand shows on `hi_q`/`lo_q` in the cycle where `done` rises, two cycles after start for multiplies. A bad divider state stays hidden until the 34th cycle, when both registers are written together. Because the pair is an accumulator, one wrong result carries into every later multiply-add, so the cycle-by-cycle comparison catches it at the first completion that differs. Faults in gating, such as a write landing while busy or an illegal code starting the unit, show as HI, LO or `busy` moving in a cycle where they should hold.

// File: rtl/hilo_mac_pkg.sv
package hilo_mac_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_MULS  = 4'd0,
    OP_MULU  = 4'd1,
    OP_MADDS = 4'd2,
    OP_MADDU = 4'd3,
    OP_MSUBS = 4'd4,
    OP_MSUBU = 4'd5,
    OP_WMUL  = 4'd6,
    OP_DIVS  = 4'd7
  } hilo_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_DIV  = 2'd2
  } hilo_state_e;

  function automatic logic op_is_legal(input logic [OP_W-1:0] code);
    return code[OP_W-1] == 1'b0;
  endfunction

  function automatic logic op_is_div(input logic [OP_W-1:0] code);
    return code == OP_DIVS;
  endfunction

endpackage

// File: rtl/hilo_mul_stage.sv
module hilo_mul_stage
  import hilo_mac_pkg::*;
#(
  parameter int W = 32,
  localparam int DW = 2 * W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [DW-1:0]   acc,
  output logic [DW-1:0]   result
);

  hilo_op_e      op_q;
  logic [DW-1:0] prod_q;

  function automatic logic [DW-1:0] extend(input logic [W-1:0] v, input logic sgn);
    return sgn ? {{W{v[W-1]}}, v} : {{W{1'b0}}, v};
  endfunction

  function automatic logic [DW-1:0] product(input hilo_op_e code, input logic [W-1:0] x,
                                            input logic [W-1:0] y, input logic [DW-1:0] pair);
    logic sgn;
    sgn = (code == OP_MULS) || (code == OP_MADDS) || (code == OP_MSUBS);
    if (code == OP_WMUL) return pair * extend(x, 1'b1);
    return extend(x, sgn) * extend(y, sgn);
  endfunction

  function automatic logic [DW-1:0] combine(input hilo_op_e code, input logic [DW-1:0] pair,
                                            input logic [DW-1:0] p);
    case (code)
      OP_MADDS, OP_MADDU: return pair + p;
      OP_MSUBS, OP_MSUBU: return pair - p;
      default:            return p;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_MULS;
      prod_q <= '0;
    end else if (load) begin
      op_q   <= hilo_op_e'(op);
      prod_q <= product(hilo_op_e'(op), a, b, acc);
    end
  end

  assign result = combine(op_q, acc, prod_q);

endmodule

// File: rtl/hilo_divider.sv
module hilo_divider #(
  parameter int W = 32,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         fin,
  output logic         by_zero,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);

  logic             running;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     rem_r, quo_r, dvs_r;
  logic             neg_q, neg_r, zero_r;

  function automatic logic [W-1:0] magnitude(input logic [W-1:0] v);
    return v[W-1] ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [2*W-1:0] step(input logic [W-1:0] r, input logic [W-1:0] q,
                                          input logic [W-1:0] d);
    logic [W:0] shifted, trial;
    shifted = {r, q[W-1]};
    trial   = shifted - {1'b0, d};
    if (!trial[W]) return {trial[W-1:0], q[W-2:0], 1'b1};
    return {shifted[W-1:0], q[W-2:0], 1'b0};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      rem_r   <= '0;
      quo_r   <= '0;
      dvs_r   <= '0;
      neg_q   <= 1'b0;
      neg_r   <= 1'b0;
      zero_r  <= 1'b0;
    end else if (load) begin
      running <= 1'b1;
      cnt     <= CNT_W'(W);
      rem_r   <= '0;
      quo_r   <= magnitude(dividend);
      dvs_r   <= magnitude(divisor);
      neg_q   <= dividend[W-1] ^ divisor[W-1];
      neg_r   <= dividend[W-1];
      zero_r  <= (divisor == '0);
    end else if (running) begin
      if (cnt != '0) begin
        {rem_r, quo_r} <= step(rem_r, quo_r, dvs_r);
        cnt            <= cnt - 1'b1;
      end else begin
        running <= 1'b0;
      end
    end
  end

  assign fin     = running && (cnt == '0);
  assign by_zero = zero_r;
  assign quo     = neg_q ? (~quo_r + 1'b1) : quo_r;
  assign rem     = neg_r ? (~rem_r + 1'b1) : rem_r;

endmodule

// File: rtl/hilo_seq_ctrl.sv
module hilo_seq_ctrl
  import hilo_mac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic go_div,
  input  logic div_fin,
  output logic busy,
  output logic mul_fin,
  output logic done
);

  hilo_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= mul_fin || div_fin;
      case (state)
        ST_IDLE: if (go) state <= go_div ? ST_DIV : ST_MUL;
        ST_MUL:  state <= ST_IDLE;
        ST_DIV:  if (div_fin) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy    = state != ST_IDLE;
  assign mul_fin = state == ST_MUL;

endmodule

// File: rtl/hilo_mac_unit.sv
module hilo_mac_unit
  import hilo_mac_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    opnd_a,
  input  logic [W-1:0]    opnd_b,
  input  logic            hi_wr_en,
  input  logic [W-1:0]    hi_wr_data,
  input  logic            lo_wr_en,
  input  logic [W-1:0]    lo_wr_data,
  output logic            busy,
  output logic            done,
  output logic [W-1:0]    hi_q,
  output logic [W-1:0]    lo_q
);

  localparam int DW = 2 * W;

  logic          accept, mul_load, div_load;
  logic          mul_fin, div_fin, div_zero;
  logic [DW-1:0] mac_result;
  logic [W-1:0]  div_quo, div_rem;

  assign accept   = start && !busy && op_is_legal(op);
  assign mul_load = accept && !op_is_div(op);
  assign div_load = accept && op_is_div(op);

  hilo_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (accept),
    .go_div  (op_is_div(op)),
    .div_fin (div_fin),
    .busy    (busy),
    .mul_fin (mul_fin),
    .done    (done)
  );

  hilo_mul_stage #(.W(W)) u_mul (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (mul_load),
    .op     (op),
    .a      (opnd_a),
    .b      (opnd_b),
    .acc    ({hi_q, lo_q}),
    .result (mac_result)
  );

  hilo_divider #(.W(W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (div_load),
    .dividend (opnd_a),
    .divisor  (opnd_b),
    .fin      (div_fin),
    .by_zero  (div_zero),
    .quo      (div_quo),
    .rem      (div_rem)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (mul_fin) begin
      {hi_q, lo_q} <= mac_result;
    end else if (div_fin) begin
      if (!div_zero) begin
        hi_q <= div_rem;
        lo_q <= div_quo;
      end
    end else if (!busy) begin
      if (hi_wr_en) hi_q <= hi_wr_data;
      if (lo_wr_en) lo_q <= lo_wr_data;
    end
  end

endmodule

// File: rtl/hilo_mac_chk.sv
module hilo_mac_chk
  import hilo_mac_pkg::*;
#(
  parameter int W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [OP_W-1:0] op,
  input logic            busy,
  input logic            done,
  input logic [W-1:0]    hi_q,
  input logic [W-1:0]    lo_q,
  input logic            div_fin,
  input logic            div_zero
);

  // R7
  mul_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !op[3] && op != 4'd7) |=> (busy ##1 (done && !busy)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  div_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op == 4'd7) |=> busy);

  // R12
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done || ($stable(hi_q) && $stable(lo_q))));

  // R10
  div_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_fin && div_zero) |=> ($stable(hi_q) && $stable(lo_q) && done));

  // R13
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op[3]) |=> !busy);

endmodule

bind hilo_mac_unit hilo_mac_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .op       (op),
  .busy     (busy),
  .done     (done),
  .hi_q     (hi_q),
  .lo_q     (lo_q),
  .div_fin  (div_fin),
  .div_zero (div_zero)
);

// File: tb/hilo_mac_unit_test.sv
module hilo_mac_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic        hi_wr_en = 1'b0, lo_wr_en = 1'b0;
  logic [31:0] hi_wr_data = '0, lo_wr_data = '0;
  logic        busy, done;
  logic [31:0] hi_q, lo_q;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  hilo_mac_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .hi_wr_en(hi_wr_en), .hi_wr_data(hi_wr_data),
    .lo_wr_en(lo_wr_en), .lo_wr_data(lo_wr_data),
    .busy(busy), .done(done), .hi_q(hi_q), .lo_q(lo_q)
  );

  // Behavioural reference: remaining cycles, pending result, flags.
  logic [31:0] m_hi = '0, m_lo = '0;
  int          m_cnt = 0;
  bit          m_done = 0;
  bit          p_write = 0;
  logic [63:0] p_res = '0;

  always @(posedge clk) begin
    longint sa, sb, ua, ub, pair, q, r;
    if (!rst_n) begin
      m_hi = '0; m_lo = '0; m_cnt = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_cnt > 0) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_done = 1;
          if (p_write) {m_hi, m_lo} = p_res;
        end
      end else begin
        pair = longint'({m_hi, m_lo});
        if (hi_wr_en) m_hi = hi_wr_data;
        if (lo_wr_en) m_lo = lo_wr_data;
        if (start && op < 4'd8) begin
          sa = longint'($signed(opnd_a)); sb = longint'($signed(opnd_b));
          ua = longint'({32'd0, opnd_a}); ub = longint'({32'd0, opnd_b});
          p_write = 1;
          m_cnt = 1;
          case (op)
            4'd0: p_res = sa * sb;
            4'd1: p_res = ua * ub;
            4'd2: p_res = longint'({m_hi, m_lo}) + sa * sb;
            4'd3: p_res = longint'({m_hi, m_lo}) + ua * ub;
            4'd4: p_res = longint'({m_hi, m_lo}) - sa * sb;
            4'd5: p_res = longint'({m_hi, m_lo}) - ua * ub;
            4'd6: p_res = pair * sa;
            default: begin
              m_cnt = 33;
              if (sb == 0) p_write = 0;
              else begin
                q = sa / sb; r = sa % sb;
                p_res = {r[31:0], q[31:0]};
              end
            end
          endcase
        end
      end
    end
  end

  // Compare every cycle, away from the rising edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (busy !== (m_cnt > 0) || done !== m_done || hi_q !== m_hi || lo_q !== m_lo) begin
        failures++;
        $display("FAIL %s: busy=%0b done=%0b hi=%08h lo=%08h expected busy=%0b done=%0b hi=%08h lo=%08h",
                 phase, busy, done, hi_q, lo_q, m_cnt > 0, m_done, m_hi, m_lo);
      end
    end
  end

  task automatic issue(input logic [3:0] code, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    start = 1'b1; op = code; opnd_a = a; opnd_b = b;
    @(negedge clk);
    start = 1'b0;
    while (m_cnt > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic load_pair(input logic [31:0] h, input logic [31:0] l);
    @(negedge clk);
    hi_wr_en = 1'b1; lo_wr_en = 1'b1; hi_wr_data = h; lo_wr_data = l;
    @(negedge clk);
    hi_wr_en = 1'b0; lo_wr_en = 1'b0;
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 5)
      0: return 32'h8000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h7FFF_FFFF;
      3: return $urandom % 16;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (hi_q !== 0 || lo_q !== 0 || busy !== 0 || done !== 0) begin
      failures++;
      $display("FAIL R1: hi=%08h lo=%08h busy=%0b done=%0b expected all zero", hi_q, lo_q, busy, done);
    end
    phase = "R2 signed multiply";    issue(4'd0, 32'h8000_0000, 32'h8000_0000);
    issue(4'd0, 32'hFFFF_FFFD, 32'h0000_0007);
    phase = "R3 unsigned multiply";  issue(4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    phase = "R4 multiply-add";       issue(4'd2, 32'h8000_0000, 32'h7FFF_FFFF);
    issue(4'd3, 32'hFFFF_FFFF, 32'h0000_0002);
    phase = "R5 multiply-subtract";  issue(4'd4, 32'hFFFF_FFFF, 32'h0000_0005);
    issue(4'd5, 32'h8000_0000, 32'h8000_0000);
    phase = "R6 wide multiply";      load_pair(32'h0000_0001, 32'h0000_0003);
    issue(4'd6, 32'hFFFF_FFFE, 32'h0);
    phase = "R7 timing";             issue(4'd1, 32'd12, 32'd13);
    phase = "R8 divide";             issue(4'd7, 32'hFFFF_FFF9, 32'd2);
    issue(4'd7, 32'd100, 32'hFFFF_FFF9);
    issue(4'd7, 32'h8000_0000, 32'hFFFF_FFFF);
    phase = "R9 divide timing";      issue(4'd7, 32'h7FFF_FFFF, 32'd1);
    phase = "R10 divide by zero";    issue(4'd7, 32'd55, 32'd0);
    phase = "R11 direct write";      load_pair(32'h1234_5678, 32'h9ABC_DEF0);
    @(negedge clk);
    hi_wr_en = 1'b1; hi_wr_data = 32'd0; lo_wr_en = 1'b1; lo_wr_data = 32'd10;
    start = 1'b1; op = 4'd2; opnd_a = 32'd3; opnd_b = 32'd4;
    @(negedge clk);
    phase = "R12 write while busy";
    start = 1'b0; hi_wr_data = 32'hDEAD_BEEF; lo_wr_data = 32'hCAFE_F00D;
    @(negedge clk);
    hi_wr_en = 1'b0; lo_wr_en = 1'b0;
    phase = "R13 start while busy";
    @(negedge clk); start = 1'b1; op = 4'd7; opnd_a = 32'd9; opnd_b = 32'd2;
    @(negedge clk); start = 1'b1; op = 4'd0; opnd_a = 32'd5; opnd_b = 32'd5;
    @(negedge clk); start = 1'b0;
    while (m_cnt > 0) @(negedge clk);
    @(negedge clk);
    phase = "R13 illegal code";      issue(4'd9, 32'd7, 32'd7);
    issue(4'd15, 32'd1, 32'd1);
    phase = "R11/R12/R13 random mix";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      start = ($urandom % 3) == 0;
      op = 4'($urandom % 10);
      opnd_a = pick(); opnd_b = ($urandom % 12 == 0) ? 32'd0 : pick();
      hi_wr_en = ($urandom % 4) == 0; hi_wr_data = pick();
      lo_wr_en = ($urandom % 4) == 0; lo_wr_data = pick();
    end
    @(negedge clk);
    start = 1'b0; hi_wr_en = 1'b0; lo_wr_en = 1'b0;
    while (m_cnt > 0) @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule